// File: doc/BRIEF.md
# Priority-Threshold Packet Admission Buffer

This block sits on the receive side of a point-to-point link. Each arriving packet is one beat: a two-bit priority, a tag and a payload word. The block holds these packets in a shared store of `DEPTH` entries. It decides whether to take a packet by comparing the number of packets already held with an occupancy threshold for that priority. One cycle after a packet arrives, the block answers the sender with exactly one response, either accept or reject. The block stores nothing of a rejected packet, and the sender is expected to retry it later.

Priorities 0, 1 and 2 take their thresholds from configuration inputs. Priority 3 always has the full depth as its threshold, so the highest class can use every free slot. Inside the store there is one first-in first-out queue per priority, and all four queues share one occupancy count. The egress port is valid/ready. It always offers the head of the highest non-empty priority. A packet at a higher priority therefore overtakes older packets at lower priorities, while packets of equal priority leave in the order they arrived. Back-pressure rules: while `out_valid` is high and `out_ready` is low and no packet arrives, the offered packet stays unchanged. A packet is removed only in a cycle where `out_valid` and `out_ready` are both high. For each priority there is a counter of accepted packets and a counter of rejected packets, so that packet conservation can be checked from the outside.

Top module: `prio_admit_buf`

## Requirements
- R1: After reset, `resp_valid` and `out_valid` are 0 and every accept and reject counter reads 0.
- R2: Every cycle with `in_valid` high produces exactly one response on the following cycle. `resp_valid` is high on that cycle, and `resp_valid` is never high without a preceding `in_valid`.
- R3: A packet with priority p (0 to 3, where 3 is highest) is accepted when the occupancy is strictly below the effective threshold of p, and rejected otherwise. A packet is never accepted while occupancy equals `DEPTH`.
- R4: The threshold for priority 3 is `DEPTH`. The thresholds for priorities 2, 1 and 0 come from `thr_p2`, `thr_p1` and `thr_p0`. Each is clamped so that it does not exceed the effective threshold of the next higher priority, and priority 2's threshold does not exceed `DEPTH`.
- R5: A rejected packet is not stored and never appears on the egress port. Occupancy counts only accepted packets that have not yet been dequeued.
- R6: `out_valid` is high exactly when some packet is held. `out_prio`, `out_tag` and `out_data` then present the oldest packet of the highest non-empty priority.
- R7: Packets of the same priority leave in their arrival order.
- R8: While `out_valid` is high, `out_ready` is low and `in_valid` is low, the egress outputs stay unchanged on the next cycle. A packet is dequeued only on a cycle where `out_valid` and `out_ready` are both high.
- R9: When an arrival and a dequeue fall in the same cycle, the admission decision uses the occupancy from before either takes effect.
- R10: `acc_count[p*CTR_W +: CTR_W]` and `rej_count[p*CTR_W +: CTR_W]` count the accepted and rejected packets of priority p. Each increments on the cycle its response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet is present this cycle |
| in_prio | input | 2 | Packet priority, 3 highest |
| in_tag | input | TAG_W | Packet tag |
| in_data | input | DATA_W | Packet payload word |
| thr_p0 | input | CNT_W | Occupancy threshold for priority 0 |
| thr_p1 | input | CNT_W | Occupancy threshold for priority 1 |
| thr_p2 | input | CNT_W | Occupancy threshold for priority 2 |
| resp_valid | output | 1 | Response for the packet of the previous cycle |
| resp_accept | output | 1 | 1 = accepted, 0 = rejected (retry) |
| out_valid | output | 1 | Egress packet available |
| out_ready | input | 1 | Consumer takes the egress packet |
| out_prio | output | 2 | Priority of the egress packet |
| out_tag | output | TAG_W | Tag of the egress packet |
| out_data | output | DATA_W | Payload of the egress packet |
| acc_count | output | 4*CTR_W | Accepted-packet counters, one field per priority |
| rej_count | output | 4*CTR_W | Rejected-packet counters, one field per priority |

## Verification
The bench fills the store one priority band at a time and probes each threshold at the exact occupancy where the decision flips. An off-by-one comparison shows up there as one packet too many or too few. It programs thresholds out of order, with a low priority given more room than a higher one and a limit above the depth. Without clamping, the low priority would then be admitted past the higher one's limit. It sends a packet in the same cycle as a dequeue, both with a threshold of 1 and with a full store. A design that used the post-dequeue count would accept a packet it should refuse. Draining checks the interleaving across priorities and the order within each priority. It also confirms that rejected tags never come out, that the head stays unchanged under back-pressure, and that the counters match the expected tallies.

// File: rtl/pab_pkg.sv
package pab_pkg;
  localparam int NUM_PRIO = 4;
  localparam int PRIO_W   = 2;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pab_fifo.sv
module pab_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign rdata    = mem[rd_ptr];
  assign nonempty = (fill != '0);
endmodule

// File: rtl/pab_admit.sv
module pab_admit #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0]   occ,
  input  pab_pkg::prio_t     prio,
  input  logic [CNT_W-1:0]   thr_p0,
  input  logic [CNT_W-1:0]   thr_p1,
  input  logic [CNT_W-1:0]   thr_p2,
  output logic               admit
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] eff [pab_pkg::NUM_PRIO];

  function automatic logic [CNT_W-1:0] cap(input logic [CNT_W-1:0] v,
                                           input logic [CNT_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // Clamp from the top down so the thresholds never decrease as priority rises.
  always_comb begin
    eff[3] = FULL;
    eff[2] = cap(thr_p2, eff[3]);
    eff[1] = cap(thr_p1, eff[2]);
    eff[0] = cap(thr_p0, eff[1]);
    admit  = (occ < eff[prio]);
  end
endmodule

// File: rtl/pab_arb.sv
module pab_arb (
  input  logic [pab_pkg::NUM_PRIO-1:0] nonempty,
  output logic                         any,
  output pab_pkg::prio_t               sel
);
  always_comb begin
    sel = '0;
    for (int p = 0; p < pab_pkg::NUM_PRIO; p++) begin
      if (nonempty[p]) sel = pab_pkg::prio_t'(p);
    end
    any = |nonempty;
  end
endmodule

// File: rtl/pab_stats.sv
module pab_stats #(
  parameter int CTR_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              event_valid,
  input  logic                              event_accept,
  input  pab_pkg::prio_t                    event_prio,
  output logic [pab_pkg::NUM_PRIO*CTR_W-1:0] acc_count,
  output logic [pab_pkg::NUM_PRIO*CTR_W-1:0] rej_count
);
  for (genvar p = 0; p < pab_pkg::NUM_PRIO; p++) begin : g_ctr
    logic [CTR_W-1:0] acc_q, rej_q;
    logic             hit;
    assign hit = event_valid && (event_prio == pab_pkg::prio_t'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q <= '0;
        rej_q <= '0;
      end else if (hit) begin
        if (event_accept) acc_q <= acc_q + 1'b1;
        else              rej_q <= rej_q + 1'b1;
      end
    end
    assign acc_count[p*CTR_W +: CTR_W] = acc_q;
    assign rej_count[p*CTR_W +: CTR_W] = rej_q;
  end
endmodule

// File: rtl/prio_admit_buf.sv
module prio_admit_buf #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int CTR_W  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_prio,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [CNT_W-1:0]         thr_p0,
  input  logic [CNT_W-1:0]         thr_p1,
  input  logic [CNT_W-1:0]         thr_p2,
  output logic                     resp_valid,
  output logic                     resp_accept,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [1:0]               out_prio,
  output logic [TAG_W-1:0]         out_tag,
  output logic [DATA_W-1:0]        out_data,
  output logic [4*CTR_W-1:0]       acc_count,
  output logic [4*CTR_W-1:0]       rej_count
);
  import pab_pkg::*;

  localparam int ENT_W = TAG_W + DATA_W;

  logic [CNT_W-1:0]    occ_q;
  logic                admit, push, pop;
  logic [NUM_PRIO-1:0] fifo_ne;
  logic [ENT_W-1:0]    head [NUM_PRIO];
  prio_t               sel;
  logic                any;
  prio_t               resp_prio_q;

  pab_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
    .occ(occ_q), .prio(in_prio),
    .thr_p0(thr_p0), .thr_p1(thr_p1), .thr_p2(thr_p2),
    .admit(admit)
  );

  assign push = in_valid && admit;
  assign pop  = any && out_ready;

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_q
    pab_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push && (in_prio == prio_t'(p))),
      .wdata({in_tag, in_data}),
      .pop(pop && (sel == prio_t'(p))),
      .rdata(head[p]),
      .nonempty(fifo_ne[p])
    );
  end

  pab_arb u_arb (.nonempty(fifo_ne), .any(any), .sel(sel));

  assign out_valid = any;
  assign out_prio  = sel;
  assign out_tag   = head[sel][ENT_W-1:DATA_W];
  assign out_data  = head[sel][DATA_W-1:0];

  // Occupancy and response; the decision above saw occ_q before this update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q       <= '0;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
      resp_prio_q <= '0;
    end else begin
      occ_q       <= occ_q + CNT_W'(push) - CNT_W'(pop);
      resp_valid  <= in_valid;
      resp_accept <= push;
      resp_prio_q <= in_prio;
    end
  end

  pab_stats #(.CTR_W(CTR_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .event_valid(resp_valid), .event_accept(resp_accept),
    .event_prio(resp_prio_q),
    .acc_count(acc_count), .rej_count(rej_count)
  );
endmodule

// File: rtl/pab_checker.sv
module pab_checker #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_prio,
  input logic [CNT_W-1:0]  occ,
  input logic [3:0]        ne,
  input logic              resp_valid,
  input logic              resp_accept,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_prio,
  input logic [TAG_W-1:0]  out_tag,
  input logic [DATA_W-1:0] out_data
);
  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> resp_valid);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !resp_valid);
  // R3
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occ >= CNT_W'(DEPTH)) |=> !resp_accept);
  // R4
  top_prio_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_prio == 2'd3 && occ < CNT_W'(DEPTH)) |=> resp_accept);
  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  // R6
  highest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((ne >> out_prio) == 4'd1));
  // R6
  empty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == (ne != 4'd0)) && (!out_valid == (occ == '0)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_valid) |=>
      (out_valid && $stable(out_prio) && $stable(out_tag) && $stable(out_data)));
endmodule

bind prio_admit_buf pab_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prio(in_prio),
  .occ(occ_q), .ne(fifo_ne), .resp_valid(resp_valid),
  .resp_accept(resp_accept), .out_valid(out_valid), .out_ready(out_ready),
  .out_prio(out_prio), .out_tag(out_tag), .out_data(out_data)
);

// File: tb/prio_admit_buf_test.sv
module prio_admit_buf_test;
  localparam int DEPTH = 8, TAG_W = 4, DATA_W = 16, CTR_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] in_prio = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [CNT_W-1:0] thr_p0 = '0, thr_p1 = '0, thr_p2 = '0;
  logic resp_valid, resp_accept, out_valid;
  logic [1:0] out_prio;
  logic [TAG_W-1:0] out_tag;
  logic [DATA_W-1:0] out_data;
  logic [4*CTR_W-1:0] acc_count, rej_count;

  int checks = 0, errors = 0;
  int exp_acc [4] = '{0, 0, 0, 0};
  int exp_rej [4] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  prio_admit_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .CTR_W(CTR_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prio(in_prio),
    .in_tag(in_tag), .in_data(in_data), .thr_p0(thr_p0), .thr_p1(thr_p1),
    .thr_p2(thr_p2), .resp_valid(resp_valid), .resp_accept(resp_accept),
    .out_valid(out_valid), .out_ready(out_ready), .out_prio(out_prio),
    .out_tag(out_tag), .out_data(out_data), .acc_count(acc_count),
    .rej_count(rej_count)
  );

  function automatic logic [DATA_W-1:0] mk_data(input logic [TAG_W-1:0] t);
    return 16'hC35A ^ (16'(t) * 16'h0123);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge; the response is read at the next falling edge.
  task automatic send(input int p, input int tag, input bit exp_ok,
                      input string req, input bit pop_too = 1'b0);
    in_valid = 1'b1; in_prio = 2'(p); in_tag = TAG_W'(tag);
    in_data = mk_data(TAG_W'(tag)); out_ready = pop_too;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R2", "resp_valid", int'(resp_valid), 1);
    chk(req, $sformatf("accept prio %0d tag %0d", p, tag), int'(resp_accept), int'(exp_ok));
    if (exp_ok) exp_acc[p]++; else exp_rej[p]++;
  endtask

  task automatic pop(input int p, input int tag, input string req);
    chk("R6", "out_valid before pop", int'(out_valid), 1);
    chk(req, "out_prio", int'(out_prio), p);
    chk(req, "out_tag", int'(out_tag), tag);
    chk(req, "out_data", int'(out_data), int'(mk_data(TAG_W'(tag))));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic check_counters(input string label);
    for (int p = 0; p < 4; p++) begin
      chk("R10", $sformatf("%s acc p%0d", label, p), int'(acc_count[p*CTR_W +: CTR_W]), exp_acc[p]);
      chk("R10", $sformatf("%s rej p%0d", label, p), int'(rej_count[p*CTR_W +: CTR_W]), exp_rej[p]);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "resp_valid", int'(resp_valid), 0);
    chk("R1", "out_valid", int'(out_valid), 0);
    check_counters("R1 reset");
    @(negedge clk);
    chk("R2", "no response without packet", int'(resp_valid), 0);
  endtask

  // Threshold bands 2/4/6/8, then a full drain showing order and no rejected tags.
  task automatic t_admit;
    thr_p0 = 2; thr_p1 = 4; thr_p2 = 6;
    @(negedge clk);
    send(0, 1, 1, "R3"); send(0, 2, 1, "R3"); send(0, 3, 0, "R3");
    send(1, 4, 1, "R3"); send(1, 5, 1, "R3"); send(1, 6, 0, "R3");
    send(2, 7, 1, "R3"); send(2, 8, 1, "R3"); send(2, 9, 0, "R3");
    send(3, 10, 1, "R4"); send(3, 11, 1, "R4"); send(3, 12, 0, "R3 full");
    pop(3, 10, "R6"); pop(3, 11, "R7");
    pop(2, 7, "R6");  pop(2, 8, "R7");
    pop(1, 4, "R6");  pop(1, 5, "R7");
    pop(0, 1, "R6");  pop(0, 2, "R5");
    chk("R5", "empty after accepted drained", int'(out_valid), 0);
    check_counters("admit");
  endtask

  // Out-of-order programming: effective p2=8, p1=3, p0=3.
  task automatic t_clamp;
    thr_p0 = 7; thr_p1 = 3; thr_p2 = 9;
    @(negedge clk);
    send(0, 1, 1, "R4"); send(0, 2, 1, "R4"); send(0, 3, 1, "R4");
    send(0, 4, 0, "R4 clamp");
    for (int i = 0; i < 5; i++) send(2, 5 + i, 1, "R4");
    send(2, 10, 0, "R4 cap at depth");
    for (int i = 0; i < 5; i++) pop(2, 5 + i, "R7");
    pop(0, 1, "R7"); pop(0, 2, "R7"); pop(0, 3, "R5");
    chk("R5", "empty after clamp", int'(out_valid), 0);
    check_counters("clamp");
  endtask

  task automatic t_hold;
    thr_p0 = 8; thr_p1 = 8; thr_p2 = 8;
    send(1, 3, 1, "R3"); send(1, 4, 1, "R3");
    for (int i = 0; i < 3; i++) begin
      chk("R8", "held tag", int'(out_tag), 3);
      chk("R8", "held valid", int'(out_valid), 1);
      @(negedge clk);
    end
    pop(1, 3, "R8"); pop(1, 4, "R7");
    chk("R8", "empty after hold", int'(out_valid), 0);
  endtask

  // Arrival with dequeue in the same cycle uses the pre-dequeue occupancy.
  task automatic t_simul;
    thr_p0 = 1; thr_p1 = 8; thr_p2 = 8;
    send(0, 1, 1, "R3");
    chk("R9", "head before combined cycle", int'(out_tag), 1);
    send(0, 2, 0, "R9", 1'b1);
    chk("R9", "popped while rejecting", int'(out_valid), 0);
    send(0, 3, 1, "R9");
    pop(0, 3, "R5");
    for (int i = 0; i < 8; i++) send(3, i, 1, "R4");
    send(3, 15, 0, "R9 full", 1'b1);
    send(3, 14, 1, "R9 room after pop");
    for (int i = 1; i < 8; i++) pop(3, i, "R7");
    pop(3, 14, "R7");
    chk("R5", "empty after simul", int'(out_valid), 0);
    check_counters("simul");
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_admit();
    t_clamp();
    t_hold();
    t_simul();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule